// File: doc/BRIEF.md
# Landing Pad Expectation Tracker

This block keeps the one-bit control-flow-integrity state of a hart: whether the next retired instruction must be a landing pad. Retirement logic reports each retired instruction as a single-cycle pulse. The pulse carries a two-bit kind (indirect call/jump, landing pad, or other) and the privilege level the instruction ran at. An indirect transfer arms the tracker. A landing pad disarms it. Any other instruction retired while armed produces a one-cycle software-check fault, which the trap logic outside the block handles.

Tracking is enabled separately for each privilege level:
- User and supervisor levels each use a bit of their own environment-configuration value.
- Machine level uses a bit of the machine security-configuration value.

The block does not decode instructions and does not match labels. On trap entry the live state is moved into a saved bit of the status image, and the live state is cleared. On trap return the live state is reloaded from the saved bit, and the saved bit is cleared.

Top module: `lpad_tracker`

## Requirements
- R1: The reset `rstN` is synchronous and active-low. A clock edge with `rstN` low sets `lpState` to 0, `savedLp` to 0 and `swCheckFault` to 0. `lpState` encodes idle as 0 and expected as 1.
- R2: Tracking is enabled at the current level and the tracker is idle. A retire pulse of kind indirect (`retireKind` = 1) sets `lpState` to 1 at that edge.
- R3: The tracker is expected. A retire pulse of kind landing pad (`retireKind` = 2) returns `lpState` to 0 and raises no fault.
- R4: Tracking is enabled and the tracker is expected. Any retire pulse that is not a landing pad (kind 0 or 1) sets `swCheckFault` high for the next cycle only and leaves `lpState` at 1.
- R5: The tracking enable is chosen by `privLevel`:
  - user (0) uses bit ENV_EN_BIT (default 2) of `userEnvCfg`;
  - supervisor (1) uses bit ENV_EN_BIT of `supEnvCfg`;
  - machine (3) uses bit SEC_EN_BIT (default 10) of `machSecCfg`;
  - the reserved level 2 is always disabled.
- R6: A retire pulse at a level where tracking is disabled leaves `lpState` at 0, or forces it to 0, and raises no fault.
- R7: `trapEnter` copies `lpState` into `savedLp` and clears `lpState` at that edge. It raises no fault. It takes priority over `trapReturn` and over a retire pulse in the same cycle.
- R8: `trapReturn` without `trapEnter` loads `lpState` from `savedLp` and clears `savedLp`. It takes priority over a retire pulse in the same cycle.
- R9: With `retireValid` low and no trap event, `lpState` and `savedLp` hold and no fault is raised, whatever `retireKind` carries.
- R10: In the idle state, a retire pulse of kind other (0) or landing pad (2) leaves `lpState` at 0 and raises no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| retireValid | input | 1 | One retired instruction this cycle |
| retireKind | input | 2 | 0 other, 1 indirect call/jump, 2 landing pad |
| privLevel | input | 2 | 0 user, 1 supervisor, 3 machine |
| userEnvCfg | input | CFG_W | User-level environment configuration |
| supEnvCfg | input | CFG_W | Supervisor-level environment configuration |
| machSecCfg | input | SEC_W | Machine security configuration |
| trapEnter | input | 1 | Trap taken this cycle |
| trapReturn | input | 1 | Trap return this cycle |
| lpState | output | 1 | Live state: 1 means a landing pad is expected |
| savedLp | output | 1 | Saved-state bit of the status image |
| swCheckFault | output | 1 | One-cycle software-check fault |

## Verification
The bench builds the block with its default parameters: 64-bit configuration inputs, enable bit 2 for user and supervisor, and enable bit 10 for machine. With these values it can set a neighbouring bit (bit 3) alone and confirm that only the correct bit position arms the tracker. It can also walk every privilege encoding, including the reserved one. The fixed widths let it toggle each level's enable on its own, so it can disable tracking while armed and show the forced return to idle.

// File: rtl/lpad_pkg.sv
package lpad_pkg;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_EXPECT = 1'b1
  } lpState_t;

  typedef enum logic [1:0] {
    KIND_OTHER    = 2'd0,
    KIND_INDIRECT = 2'd1,
    KIND_LPAD     = 2'd2,
    KIND_RSVD     = 2'd3
  } retireKind_t;

  localparam logic [1:0] PRIV_USER = 2'd0;
  localparam logic [1:0] PRIV_SUP  = 2'd1;
  localparam logic [1:0] PRIV_MACH = 2'd3;

  // strobes from control to datapath; at most one state strobe per cycle
  typedef struct packed {
    logic arm;
    logic disarm;
    logic saveClear;
    logic restore;
    logic raiseFault;
  } lpStrobes_t;

endpackage

// File: rtl/lpad_ctrl.sv
module lpad_ctrl
  import lpad_pkg::*;
#(
  parameter int CFG_W      = 64,
  parameter int SEC_W      = 64,
  parameter int ENV_EN_BIT = 2,
  parameter int SEC_EN_BIT = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             retireValid,
  input  logic [1:0]       retireKind,
  input  logic [1:0]       privLevel,
  input  logic [CFG_W-1:0] userEnvCfg,
  input  logic [CFG_W-1:0] supEnvCfg,
  input  logic [SEC_W-1:0] machSecCfg,
  input  logic             trapEnter,
  input  logic             trapReturn,
  input  lpState_t         curState,
  output lpStrobes_t       strobes,
  output logic             swCheckFault
);

  logic trackEn;
  logic isLpad;

  always_comb begin
    case (privLevel)
      PRIV_USER: trackEn = userEnvCfg[ENV_EN_BIT];
      PRIV_SUP:  trackEn = supEnvCfg[ENV_EN_BIT];
      PRIV_MACH: trackEn = machSecCfg[SEC_EN_BIT];
      default:   trackEn = 1'b0;
    endcase
  end

  assign isLpad = (retireKind == KIND_LPAD);

  always_comb begin
    strobes = '0;
    if (trapEnter) begin
      strobes.saveClear = 1'b1;
    end else if (trapReturn) begin
      strobes.restore = 1'b1;
    end else if (retireValid) begin
      if (!trackEn) begin
        strobes.disarm = (curState == ST_EXPECT);
      end else if (curState == ST_IDLE) begin
        strobes.arm = (retireKind == KIND_INDIRECT);
      end else if (isLpad) begin
        strobes.disarm = 1'b1;
      end else begin
        strobes.raiseFault = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) swCheckFault <= 1'b0;
    else       swCheckFault <= strobes.raiseFault;
  end

  // a fault cycle follows an edge where the state did not move
  p_fault_hold_r4 : assert property (@(posedge clk) disable iff (!rstN)
    swCheckFault |-> (curState == ST_EXPECT) && (curState == $past(curState)));

  // disabled level: no fault and idle afterwards
  p_disabled_quiet_r6 : assert property (@(posedge clk) disable iff (!rstN)
    (retireValid && !trackEn && !trapEnter && !trapReturn)
      |=> (!swCheckFault && curState == ST_IDLE));

endmodule

// File: rtl/lpad_datapath.sv
module lpad_datapath
  import lpad_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  lpStrobes_t strobes,
  output lpState_t   curState,
  output logic       savedBit
);

  lpState_t nextState;
  logic     nextSaved;

  always_comb begin
    nextState = curState;
    nextSaved = savedBit;
    if (strobes.saveClear) begin
      nextSaved = curState;
      nextState = ST_IDLE;
    end else if (strobes.restore) begin
      nextState = lpState_t'(savedBit);
      nextSaved = 1'b0;
    end else if (strobes.arm) begin
      nextState = ST_EXPECT;
    end else if (strobes.disarm) begin
      nextState = ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curState <= ST_IDLE;
      savedBit <= 1'b0;
    end else begin
      curState <= nextState;
      savedBit <= nextSaved;
    end
  end

  p_one_strobe_r7 : assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.arm, strobes.disarm, strobes.saveClear, strobes.restore}));

  p_arm_sets_r2 : assert property (@(posedge clk) disable iff (!rstN)
    strobes.arm |=> curState == ST_EXPECT);

endmodule

// File: rtl/lpad_tracker.sv
module lpad_tracker
  import lpad_pkg::*;
#(
  parameter int CFG_W      = 64,
  parameter int SEC_W      = 64,
  parameter int ENV_EN_BIT = 2,
  parameter int SEC_EN_BIT = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             retireValid,
  input  logic [1:0]       retireKind,
  input  logic [1:0]       privLevel,
  input  logic [CFG_W-1:0] userEnvCfg,
  input  logic [CFG_W-1:0] supEnvCfg,
  input  logic [SEC_W-1:0] machSecCfg,
  input  logic             trapEnter,
  input  logic             trapReturn,
  output logic             lpState,
  output logic             savedLp,
  output logic             swCheckFault
);

  lpStrobes_t strobes;
  lpState_t   curState;

  lpad_ctrl #(
    .CFG_W(CFG_W), .SEC_W(SEC_W),
    .ENV_EN_BIT(ENV_EN_BIT), .SEC_EN_BIT(SEC_EN_BIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .retireValid(retireValid), .retireKind(retireKind), .privLevel(privLevel),
    .userEnvCfg(userEnvCfg), .supEnvCfg(supEnvCfg), .machSecCfg(machSecCfg),
    .trapEnter(trapEnter), .trapReturn(trapReturn),
    .curState(curState), .strobes(strobes), .swCheckFault(swCheckFault)
  );

  lpad_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .curState(curState), .savedBit(savedLp)
  );

  assign lpState = curState;

  p_trap_save_r7 : assert property (@(posedge clk) disable iff (!rstN)
    trapEnter |=> (savedLp == $past(lpState)) && !lpState && !swCheckFault);

  p_trap_return_r8 : assert property (@(posedge clk) disable iff (!rstN)
    (trapReturn && !trapEnter) |=> (lpState == $past(savedLp)) && !savedLp);

  p_hold_r9 : assert property (@(posedge clk) disable iff (!rstN)
    (!retireValid && !trapEnter && !trapReturn)
      |=> $stable(lpState) && $stable(savedLp) && !swCheckFault);

endmodule

// File: tb/lpad_tracker_tb.sv
module lpad_tracker_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        retireValid;
  logic [1:0]  retireKind;
  logic [1:0]  privLevel;
  logic [63:0] userEnvCfg, supEnvCfg, machSecCfg;
  logic        trapEnter, trapReturn;
  logic        lpState, savedLp, swCheckFault;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  lpad_tracker u_dut (
    .clk(clk), .rstN(rstN), .retireValid(retireValid), .retireKind(retireKind),
    .privLevel(privLevel), .userEnvCfg(userEnvCfg), .supEnvCfg(supEnvCfg),
    .machSecCfg(machSecCfg), .trapEnter(trapEnter), .trapReturn(trapReturn),
    .lpState(lpState), .savedLp(savedLp), .swCheckFault(swCheckFault)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic expect3(string tag, logic expLp, logic expSaved, logic expFault);
    nChecks++;
    if (lpState !== expLp || savedLp !== expSaved || swCheckFault !== expFault) begin
      nFails++;
      $display("FAIL %s: lp/saved/fault actual %b%b%b expected %b%b%b",
               tag, lpState, savedLp, swCheckFault, expLp, expSaved, expFault);
    end
  endtask

  task automatic retire(logic [1:0] kind, logic [1:0] priv);
    retireValid = 1'b1; retireKind = kind; privLevel = priv;
    step();
    retireValid = 1'b0; retireKind = 2'd0;
  endtask

  task automatic idleCycle();
    step();
  endtask

  task automatic doReset();
    rstN = 1'b0;
    retireValid = 1'b0; retireKind = 2'd0; privLevel = 2'd3;
    userEnvCfg = '0; supEnvCfg = '0; machSecCfg = '0;
    trapEnter = 1'b0; trapReturn = 1'b0;
    step(); step();
    rstN = 1'b1;
  endtask

  task automatic t_reset();
    // arm, save it, then reset to show all cleared (R1)
    machSecCfg = 64'h400;
    retire(2'd1, 2'd3);
    trapEnter = 1'b1; step(); trapEnter = 1'b0;
    retire(2'd1, 2'd3);
    retire(2'd0, 2'd3);
    rstN = 1'b0; step(); rstN = 1'b1;
    expect3("R1 reset", 1'b0, 1'b0, 1'b0);
    machSecCfg = '0;
  endtask

  task automatic t_arm_land();
    machSecCfg = 64'h400;
    retire(2'd1, 2'd3); expect3("R2 arm machine", 1'b1, 1'b0, 1'b0);
    retire(2'd2, 2'd3); expect3("R3 land", 1'b0, 1'b0, 1'b0);
    machSecCfg = '0;
  endtask

  task automatic t_violation();
    machSecCfg = 64'h400;
    retire(2'd1, 2'd3);
    retire(2'd0, 2'd3); expect3("R4 other while armed", 1'b1, 1'b0, 1'b1);
    idleCycle();        expect3("R4 fault one cycle", 1'b1, 1'b0, 1'b0);
    retire(2'd1, 2'd3); expect3("R4 indirect while armed", 1'b1, 1'b0, 1'b1);
    retire(2'd2, 2'd3); expect3("R4 land after fault", 1'b0, 1'b0, 1'b0);
    machSecCfg = '0;
  endtask

  task automatic t_enable_sel();
    userEnvCfg = 64'h4;
    retire(2'd1, 2'd0); expect3("R5 user bit2 arms", 1'b1, 1'b0, 1'b0);
    retire(2'd2, 2'd0);
    retire(2'd1, 2'd1); expect3("R5 sup off", 1'b0, 1'b0, 1'b0);
    retire(2'd1, 2'd3); expect3("R5 mach off", 1'b0, 1'b0, 1'b0);
    retire(2'd1, 2'd2); expect3("R5 reserved level", 1'b0, 1'b0, 1'b0);
    userEnvCfg = 64'h8;
    retire(2'd1, 2'd0); expect3("R5 user wrong bit", 1'b0, 1'b0, 1'b0);
    userEnvCfg = '0; supEnvCfg = 64'h4;
    retire(2'd1, 2'd1); expect3("R5 sup bit2 arms", 1'b1, 1'b0, 1'b0);
    retire(2'd2, 2'd1);
    supEnvCfg = '0; machSecCfg = 64'h200;
    retire(2'd1, 2'd3); expect3("R5 mach wrong bit", 1'b0, 1'b0, 1'b0);
    userEnvCfg = 64'hFFFF_FFFF_FFFF_FFFF; supEnvCfg = 64'hFFFF_FFFF_FFFF_FFFF;
    machSecCfg = 64'hFFFF_FFFF_FFFF_FFFF;
    retire(2'd1, 2'd2); expect3("R5 reserved all set", 1'b0, 1'b0, 1'b0);
    userEnvCfg = '0; supEnvCfg = '0; machSecCfg = '0;
  endtask

  task automatic t_disabled();
    retire(2'd1, 2'd3); expect3("R6 disabled no arm", 1'b0, 1'b0, 1'b0);
    machSecCfg = 64'h400;
    retire(2'd1, 2'd3);
    machSecCfg = '0;
    retire(2'd0, 2'd3); expect3("R6 disabled forces idle", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_trap();
    machSecCfg = 64'h400;
    retire(2'd1, 2'd3);
    trapEnter = 1'b1; retireValid = 1'b1; retireKind = 2'd0; trapReturn = 1'b1;
    step();
    trapEnter = 1'b0; retireValid = 1'b0; trapReturn = 1'b0;
    expect3("R7 trap entry saves", 1'b0, 1'b1, 1'b0);
    idleCycle(); expect3("R9 hold saved", 1'b0, 1'b1, 1'b0);
    trapReturn = 1'b1; retireValid = 1'b1; retireKind = 2'd2;
    step();
    trapReturn = 1'b0; retireValid = 1'b0;
    expect3("R8 trap return restores", 1'b1, 1'b0, 1'b0);
    trapReturn = 1'b1; step(); trapReturn = 1'b0;
    expect3("R8 return with clear saved", 1'b0, 1'b0, 1'b0);
    machSecCfg = '0;
  endtask

  task automatic t_quiet();
    machSecCfg = 64'h400;
    retire(2'd0, 2'd3); expect3("R10 idle other", 1'b0, 1'b0, 1'b0);
    retire(2'd2, 2'd3); expect3("R10 idle lpad", 1'b0, 1'b0, 1'b0);
    retire(2'd1, 2'd3);
    retireValid = 1'b0; retireKind = 2'd0; step();
    expect3("R9 no pulse armed", 1'b1, 1'b0, 1'b0);
    retireKind = 2'd2; step(); retireKind = 2'd0;
    expect3("R9 no pulse lpad kind", 1'b1, 1'b0, 1'b0);
    retire(2'd2, 2'd3);
    machSecCfg = '0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    doReset();
    expect3("R1 after reset", 1'b0, 1'b0, 1'b0);
    t_arm_land();
    t_violation();
    t_enable_sel();
    t_disabled();
    t_trap();
    t_quiet();
    t_reset();
    finish();
  end

  initial begin
    #50000;
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

endmodule